// File: doc/BRIEF.md
# AC97 Command Slot Register Unit

This block keeps the two command words of an AC97 link: a 19-bit command address and a 20-bit command data word. Either register can be loaded by a direct write from the register port or overwritten when a command slot arrives from the codec. Whenever an update actually changes a stored value, a sticky status flag for that register is raised. Software clears each flag with its own write-one-to-clear strobe.

On the transmit side the block supplies the slot 1 and slot 2 payloads to an external serializer. The top bit of the slot 1 payload is not stored. It comes from the read-command control. The slot 2 payload carries the stored data only during a write command. Frame timing and bit serialization belong to other blocks.

Top module: `ac97_cmd_regs`

## Requirements
- R1: After reset both registers, both flags and both slot payloads are zero.
- R2: The address register holds 19 bits. A read with `bus_rd_sel`=0 returns the address in bits 18:0 and zero in bits 31:19.
- R3: The data register holds 20 bits. A read with `bus_rd_sel`=1 returns the data in bits 19:0 and zero in bits 31:20.
- R4: A write with `bus_wr_en`=1 loads `bus_wdata` into the register chosen by `bus_sel` (0 = address, 1 = data) on the next clock edge. A register with no update holds its value.
- R5: A receive strobe (`rx_addr_vld` or `rx_data_vld`) loads the received slot into its register. When a bus write targets the same register in the same cycle, the received value wins.
- R6: `addr_flag` is set in the cycle after an update that changes the address register. An update that rewrites the stored value leaves the flag as it was.
- R7: `data_flag` behaves the same way for the data register.
- R8: Both flags are sticky until their clear strobe is pulsed. If a change and a clear arrive in the same cycle, the flag stays set.
- R9: With `cmd_rd` or `cmd_wr` asserted, `slot1_out` is {`cmd_rd`, address}. When neither is asserted, `slot1_out` is zero.
- R10: `slot2_out` equals the data register only while `cmd_wr`=1 and `cmd_rd`=0. In every other case it is zero, so a read takes precedence when both controls are asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_sel | input | 1 | Write target: 0 address, 1 data |
| bus_wdata | input | 32 | Write data |
| bus_rd_sel | input | 1 | Read source: 0 address, 1 data |
| bus_rdata | output | 32 | Read data, zero-extended |
| rx_addr_vld | input | 1 | Received address slot strobe |
| rx_addr | input | 19 | Received address slot payload |
| rx_data_vld | input | 1 | Received data slot strobe |
| rx_data | input | 20 | Received data slot payload |
| cmd_rd | input | 1 | Read command active |
| cmd_wr | input | 1 | Write command active |
| clr_addr_flag | input | 1 | Clear strobe for the address flag |
| clr_data_flag | input | 1 | Clear strobe for the data flag |
| addr_flag | output | 1 | Address changed flag |
| data_flag | output | 1 | Data changed flag |
| slot1_out | output | 20 | Slot 1 payload |
| slot2_out | output | 20 | Slot 2 payload |

## Verification
The assertions are checked on every cycle. They cover the following: a register holds its value when it has no update, a flag follows any change of its register, a flag stays set until it is cleared, the unused read bits are zero, and the two slot payloads take their idle and read-command zeros.

Some behaviours can only be shown by the bench scenarios, because they depend on the values sent in:
- a rewrite of an unchanged value does not raise a flag;
- a received slot wins over a colliding bus write;
- a set wins over a clear in the same cycle.

The bench sweeps values through both sources with collisions, repeats and clears mixed in. It compares every readback and flag against its own model.

// File: rtl/ac97_cmd_regs.sv
module ac97_cmd_regs #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 20,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic              bus_sel,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_rd_sel,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              rx_addr_vld,
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic              rx_data_vld,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              cmd_rd,
  input  logic              cmd_wr,
  input  logic              clr_addr_flag,
  input  logic              clr_data_flag,
  output logic              addr_flag,
  output logic              data_flag,
  output logic [ADDR_W:0]   slot1_out,
  output logic [DATA_W-1:0] slot2_out
);

  logic [ADDR_W-1:0] addr_q, addr_nx;
  logic [DATA_W-1:0] data_q, data_nx;
  logic              cmd_any, wr_only;

  always_comb begin
    addr_nx = addr_q;
    if (rx_addr_vld)                addr_nx = rx_addr;
    else if (bus_wr_en && !bus_sel) addr_nx = bus_wdata[ADDR_W-1:0];
  end

  always_comb begin
    data_nx = data_q;
    if (rx_data_vld)               data_nx = rx_data;
    else if (bus_wr_en && bus_sel) data_nx = bus_wdata[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q    <= '0;
      data_q    <= '0;
      addr_flag <= 1'b0;
      data_flag <= 1'b0;
    end else begin
      addr_q    <= addr_nx;
      data_q    <= data_nx;
      addr_flag <= (addr_nx != addr_q) | (addr_flag & ~clr_addr_flag);
      data_flag <= (data_nx != data_q) | (data_flag & ~clr_data_flag);
    end
  end

  assign bus_rdata = bus_rd_sel ? BUS_W'(data_q) : BUS_W'(addr_q);

  assign cmd_any   = cmd_rd | cmd_wr;
  assign wr_only   = cmd_wr & ~cmd_rd;
  assign slot1_out = cmd_any ? {cmd_rd, addr_q} : '0;
  assign slot2_out = wr_only ? data_q : '0;

  a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_addr_vld || (bus_wr_en && !bus_sel)) |=> $stable(addr_q));
  a_r4_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_data_vld || (bus_wr_en && bus_sel)) |=> $stable(data_q));
  a_r6_addr_flag_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_q != $past(addr_q)) |-> addr_flag);
  a_r7_data_flag_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (data_q != $past(data_q)) |-> data_flag);
  a_r8_addr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_flag && !clr_addr_flag) |=> addr_flag);
  a_r8_data_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (data_flag && !clr_data_flag) |=> data_flag);
  a_r2_addr_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_sel |-> (bus_rdata[BUS_W-1:ADDR_W] == '0));
  a_r3_data_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_sel |-> (bus_rdata[BUS_W-1:DATA_W] == '0));
  a_r9_slot1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_rd || cmd_wr) |-> (slot1_out == '0));
  a_r10_slot2_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rd |-> (slot2_out == '0));

endmodule

// File: tb/ac97_cmd_regs_tb_top.sv
module ac97_cmd_regs_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr_en = 0, bus_sel = 0, bus_rd_sel = 0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        rx_addr_vld = 0, rx_data_vld = 0;
  logic [18:0] rx_addr = '0;
  logic [19:0] rx_data = '0;
  logic        cmd_rd = 0, cmd_wr = 0, clr_addr_flag = 0, clr_data_flag = 0;
  logic        addr_flag, data_flag;
  logic [19:0] slot1_out, slot2_out;

  int checks = 0, errors = 0;
  logic [18:0] m_addr = '0;
  logic [19:0] m_data = '0;
  logic        m_af = 0, m_df = 0;

  always #5 clk = ~clk;

  ac97_cmd_regs dut_i (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check_state(string tag);
    bus_rd_sel = 0; #1;
    check({tag, " R2 R4 R5 addr readback"}, bus_rdata, {13'd0, m_addr});
    bus_rd_sel = 1; #1;
    check({tag, " R3 R4 R5 data readback"}, bus_rdata, {12'd0, m_data});
    check({tag, " R6 R8 addr_flag"}, {31'd0, addr_flag}, {31'd0, m_af});
    check({tag, " R7 R8 data_flag"}, {31'd0, data_flag}, {31'd0, m_df});
  endtask

  task automatic check_slots();
    for (int c = 0; c < 4; c++) begin
      logic [19:0] e1, e2;
      cmd_rd = c[1]; cmd_wr = c[0]; #1;
      e1 = (cmd_rd | cmd_wr) ? {cmd_rd, m_addr} : 20'd0;
      e2 = (cmd_wr & ~cmd_rd) ? m_data : 20'd0;
      check("R9 slot1", {12'd0, slot1_out}, {12'd0, e1});
      check("R10 slot2", {12'd0, slot2_out}, {12'd0, e2});
    end
    cmd_rd = 0; cmd_wr = 0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1; step();
    check_state("R1 reset");
    check_slots();

    bus_wr_en = 1; bus_sel = 0; bus_wdata = 32'hFFFF_FFFF; step();
    bus_wr_en = 0;
    m_addr = 19'h7FFFF; m_af = 1;
    check_state("R2 full write");

    clr_addr_flag = 1; step(); clr_addr_flag = 0; m_af = 0;
    check_state("R8 clear");
    bus_wr_en = 1; bus_sel = 0; bus_wdata = 32'hFFFF_FFFF; step(); bus_wr_en = 0;
    check_state("R6 same value no flag");

    bus_wr_en = 1; bus_sel = 1; bus_wdata = 32'hFFFF_FFFF; step(); bus_wr_en = 0;
    m_data = 20'hFFFFF; m_df = 1;
    check_state("R3 full write");
    check_slots();

    for (int i = 0; i < 96; i++) begin
      logic [31:0] v, w;
      logic [18:0] na;
      logic [19:0] nd;
      v = i * 32'h9E37_79B1 + 32'h1234_5678;
      w = v ^ 32'h5A5A_A5A5;
      if (i % 4 == 3) v = {12'd0, m_data};
      na = m_addr; nd = m_data;
      bus_wr_en = (i % 2 == 0) || (i % 5 == 0);
      bus_sel = i[2];
      bus_wdata = w;
      rx_addr_vld = (i % 3 == 1) || (i % 5 == 0);
      rx_addr = (i % 4 == 3) ? m_addr : v[18:0];
      rx_data_vld = (i % 3 == 2) || (i % 5 == 0);
      rx_data = v[19:0];
      clr_addr_flag = (i % 7 == 0);
      clr_data_flag = (i % 6 == 0);
      if (rx_addr_vld) na = rx_addr;
      else if (bus_wr_en && !bus_sel) na = w[18:0];
      if (rx_data_vld) nd = rx_data;
      else if (bus_wr_en && bus_sel) nd = w[19:0];
      step();
      m_af = (na != m_addr) | (m_af & ~clr_addr_flag);
      m_df = (nd != m_data) | (m_df & ~clr_data_flag);
      m_addr = na; m_data = nd;
      bus_wr_en = 0; rx_addr_vld = 0; rx_data_vld = 0;
      clr_addr_flag = 0; clr_data_flag = 0;
      check_state("sweep");
      if (i % 8 == 0) check_slots();
    end

    bus_wr_en = 1; bus_sel = 1; bus_wdata = 32'h000A_AAAA;
    rx_data_vld = 1; rx_data = 20'h5_5555; step();
    bus_wr_en = 0; rx_data_vld = 0;
    m_df = m_df | (m_data != 20'h5_5555); m_data = 20'h5_5555;
    check_state("R5 collision");

    bus_wr_en = 1; bus_sel = 0; bus_wdata = {13'd0, ~m_addr}; clr_addr_flag = 1; step();
    bus_wr_en = 0; clr_addr_flag = 0; m_addr = ~m_addr; m_af = 1;
    check_state("R8 set beats clear");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule